// File: doc/BRIEF.md
# Real-Time Tick Counter with Dual Alarm

This block is a memory-mapped real-time clock that runs from a 32768 Hz clock. A programmable prescaler divides the clock down to a sub-second tick. Each tick advances a 32-bit time counter. The low four counter bits count sixteenths of a second and bits 31:4 count whole seconds. Software can load the counter at any time.

Two alarm compare registers watch the counter. A status register holds three event bits: alarm 0, alarm 1 and a once-per-second event. Each event bit has an enable bit next to it, and the enabled events are combined into one interrupt output. The block also holds a scratch word, which software uses to keep an overflow epoch across counter wraps. It further holds a deep-control word and a clock-source selector that gates the prescaler.

All access goes through a simple synchronous bus with an address, a write strobe, write data and registered read data. A read returns the register selected by the address one cycle after the address is presented.

Top module: `rtc_tick_alarm`

## Requirements
- R1: After reset the block holds these values: counter 0, both alarms 0, status 0, divider 1023, clock selector 0, deep-control 0, scratch 0, and irq_o low.
- R2: Writing 3 to the clock selector at 0x1C starts the time base. Writing any other value stores 0, reads back as 0 and freezes both the counter and the prescaler.
- R3: While the selector holds 3, the counter at 0x00 increments once every 2×(DIV+1) clocks, where DIV is the divider at 0x0C. The counter wraps from 0xFFFFFFFF to 0.
- R4: A write to 0x00 loads the counter and restarts the prescaler, so the next increment comes a full period after the write edge. If a write and a tick fall on the same edge, the write wins and the tick is lost.
- R5: Status bit 1 (seconds event) sets on the tick edge at which counter bits 3:0 roll from 15 to 0. This happens whatever the state of its enable bit (bit 3).
- R6: Status bit 0 (alarm 0 event) sets on a tick edge that moves the counter onto the value in alarm 0 (at 0x04), but only if bit 2 (alarm 0 enable) is set. With the enable clear, the event bit stays clear.
- R7: Status bit 4 (alarm 1 event) follows the same rule for alarm 1 (at 0x18), gated by bit 6 (alarm 1 enable).
- R8: A status write clears each event bit (bits 0, 1, 4) whose write-data bit is 1 and leaves it unchanged where the bit is 0. A new event on the same edge wins over the clear. The enable bits (2, 3, 6) are plain read/write, and the other status bits read as 0.
- R9: An alarm register may be rewritten while its enable is set. Matching then follows only the new value.
- R10: irq_o is high one clock after any event bit and its paired enable bit are both set, and low one clock after no such pair is set.
- R11: The scratch word (0x40, 32 bits), deep-control (0x14, low 8 bits) and divider (0x0C, low 16 bits) hold whatever is written to them. Counter activity never changes them.
- R12: bus_rdata shows, one clock after an address is presented, the value the addressed register held at that edge. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz clock driving all logic |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the accessed register |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A register write takes effect at the edge that samples it. bus_rdata and irq_o are both registered, so each shows the state one edge later. A counter increment, and any event it raises, appear together on the tick edge, which comes 2×(DIV+1) edges after the previous tick or after the counter write. The bench model follows this count edge by edge, including the lost tick when a write lands on a tick edge. The bench compares read data and the interrupt at every falling edge, halfway between the edge that produced them and the next. Targeted literal checks are placed where the timing gives a stable value, for example with the time base frozen.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_AW = 8;

  localparam logic [RTC_AW-1:0] ADR_CNT  = 8'h00;
  localparam logic [RTC_AW-1:0] ADR_AL0  = 8'h04;
  localparam logic [RTC_AW-1:0] ADR_STAT = 8'h08;
  localparam logic [RTC_AW-1:0] ADR_DIV  = 8'h0C;
  localparam logic [RTC_AW-1:0] ADR_DEEP = 8'h14;
  localparam logic [RTC_AW-1:0] ADR_AL1  = 8'h18;
  localparam logic [RTC_AW-1:0] ADR_SEL  = 8'h1C;
  localparam logic [RTC_AW-1:0] ADR_SCR  = 8'h40;

  localparam int SEL_RTC = 3;
  localparam int NUM_AL  = 2;
  localparam int NUM_EV  = 3;

  // event index: 0 alarm0, 1 seconds, 2 alarm1
  function automatic int ev_bit(input int i);
    case (i)
      0:       return 0;
      1:       return 1;
      default: return 4;
    endcase
  endfunction

  function automatic int en_bit(input int i);
    case (i)
      0:       return 2;
      1:       return 3;
      default: return 6;
    endcase
  endfunction

  function automatic logic [RTC_AW-1:0] alarm_adr(input int k);
    return (k == 0) ? ADR_AL0 : ADR_AL1;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PW = DIV_W + 1;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] term;

  // period is 2*(div+1): count 0 .. 2*div+1
  assign term = {div, 1'b1};
  assign tick = run && (pcnt_q >= term);

  always_ff @(posedge clk) begin
    if (rst)                  pcnt_q <= '0;
    else if (restart || tick) pcnt_q <= '0;
    else if (run)             pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] probe,
  output logic [W-1:0] value,
  output logic         hit
);
  always_ff @(posedge clk) begin
    if (rst)        value <= '0;
    else if (wr_en) value <= wr_data;
  end

  assign hit = (probe == value);
endmodule

// File: rtl/rtc_event_flag.sv
module rtc_event_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  // a fresh event outranks a same-edge clear
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= set | (flag & ~clr);
  end
endmodule

// File: rtl/rtc_tick_alarm.sv
module rtc_tick_alarm
  import rtc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 1023,
  parameter int SUB_BITS  = 4,
  parameter int DEEP_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RTC_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic              cnt_wr, stat_wr, div_wr, deep_wr, sel_wr, scr_wr;
  logic              run, tick, adv;
  logic [DATA_W-1:0] cnt_q, cnt_inc;
  logic [DIV_W-1:0]  div_q;
  logic [DEEP_W-1:0] deep_q;
  logic [1:0]        clk_sel_q;
  logic [DATA_W-1:0] scr_q;
  logic [DATA_W-1:0] alarm_q [NUM_AL];
  logic [NUM_AL-1:0] al_hit;
  logic [NUM_EV-1:0] ev_q, en_q, ev_set;
  logic [DATA_W-1:0] stat_w, rd_mux;

  assign cnt_wr  = bus_we && (bus_addr == ADR_CNT);
  assign stat_wr = bus_we && (bus_addr == ADR_STAT);
  assign div_wr  = bus_we && (bus_addr == ADR_DIV);
  assign deep_wr = bus_we && (bus_addr == ADR_DEEP);
  assign sel_wr  = bus_we && (bus_addr == ADR_SEL);
  assign scr_wr  = bus_we && (bus_addr == ADR_SCR);

  assign run     = (clk_sel_q == 2'(SEL_RTC));
  assign adv     = tick && !cnt_wr;
  assign cnt_inc = cnt_q + 1'b1;

  rtc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .restart(cnt_wr), .div(div_q), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      div_q     <= DIV_W'(DIV_RESET);
      deep_q    <= '0;
      clk_sel_q <= '0;
      scr_q     <= '0;
    end else begin
      if (cnt_wr)      cnt_q <= bus_wdata;
      else if (tick)   cnt_q <= cnt_inc;
      if (div_wr)  div_q  <= bus_wdata[DIV_W-1:0];
      if (deep_wr) deep_q <= bus_wdata[DEEP_W-1:0];
      if (scr_wr)  scr_q  <= bus_wdata;
      if (sel_wr)  clk_sel_q <= (bus_wdata == DATA_W'(SEL_RTC)) ? 2'(SEL_RTC) : 2'd0;
    end
  end

  for (genvar k = 0; k < NUM_AL; k++) begin : g_alarm
    rtc_alarm_cmp #(.W(DATA_W)) u_cmp (
      .clk(clk), .rst(rst),
      .wr_en(bus_we && (bus_addr == alarm_adr(k))),
      .wr_data(bus_wdata), .probe(cnt_inc),
      .value(alarm_q[k]), .hit(al_hit[k])
    );
  end

  assign ev_set[0] = adv && en_q[0] && al_hit[0];
  assign ev_set[1] = adv && (cnt_q[SUB_BITS-1:0] == '1);
  assign ev_set[2] = adv && en_q[2] && al_hit[1];

  for (genvar i = 0; i < NUM_EV; i++) begin : g_event
    localparam int EVP = ev_bit(i);
    rtc_event_flag u_flag (
      .clk(clk), .rst(rst), .set(ev_set[i]),
      .clr(stat_wr && bus_wdata[EVP]), .flag(ev_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (stat_wr)
      for (int i = 0; i < NUM_EV; i++) en_q[i] <= bus_wdata[en_bit(i)];
  end

  always_comb begin
    stat_w = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      stat_w[ev_bit(i)] = ev_q[i];
      stat_w[en_bit(i)] = en_q[i];
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_CNT:  rd_mux = cnt_q;
      ADR_AL0:  rd_mux = alarm_q[0];
      ADR_STAT: rd_mux = stat_w;
      ADR_DIV:  rd_mux = DATA_W'(div_q);
      ADR_DEEP: rd_mux = DATA_W'(deep_q);
      ADR_AL1:  rd_mux = alarm_q[1];
      ADR_SEL:  rd_mux = DATA_W'(clk_sel_q);
      ADR_SCR:  rd_mux = scr_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq_o     <= |(ev_q & en_q);
    end
  end
endmodule

// File: rtl/rtc_tick_alarm_chk.sv
module rtc_tick_alarm_chk
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [RTC_AW-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] cnt_q,
  input logic [NUM_EV-1:0] ev_q,
  input logic [NUM_EV-1:0] en_q,
  input logic [1:0]        clk_sel_q,
  input logic              irq_o
);
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == ADR_CNT) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // R2
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_sel_q != 2'(SEL_RTC) && !(bus_we && bus_addr == ADR_CNT)) |=> $stable(cnt_q));

  // R6
  al0_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ev_q[0]) |-> $past(en_q[0]));

  // R7
  al1_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ev_q[2]) |-> $past(en_q[2]));

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ev_q[0]) |-> $past(bus_we && bus_addr == ADR_STAT && bus_wdata[0]));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((ev_q & en_q) == '0) |=> !irq_o);
endmodule

bind rtc_tick_alarm rtc_tick_alarm_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt_q(cnt_q), .ev_q(ev_q), .en_q(en_q),
  .clk_sel_q(clk_sel_q), .irq_o(irq_o)
);

// File: tb/rtc_tick_alarm_tb_top.sv
module rtc_tick_alarm_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit live  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_tick_alarm dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // behavioural reference model
  logic [31:0] m_cnt, m_al0, m_al1, m_scr, m_rd;
  logic [15:0] m_div;
  logic [7:0]  m_deep;
  logic [1:0]  m_sel;
  logic [2:0]  m_ev, m_en;
  logic        m_irq;
  int          m_pre;

  function automatic logic [31:0] m_stat();
    logic [31:0] s = '0;
    s[0] = m_ev[0]; s[1] = m_ev[1]; s[4] = m_ev[2];
    s[2] = m_en[0]; s[3] = m_en[1]; s[6] = m_en[2];
    return s;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_cnt;
      8'h04: return m_al0;
      8'h08: return m_stat();
      8'h0C: return {16'h0, m_div};
      8'h14: return {24'h0, m_deep};
      8'h18: return m_al1;
      8'h1C: return {30'h0, m_sel};
      8'h40: return m_scr;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cnt = 0; m_al0 = 0; m_al1 = 0; m_scr = 0; m_rd = 0; m_div = 16'd1023;
      m_deep = 0; m_sel = 0; m_ev = 0; m_en = 0; m_irq = 0; m_pre = 0;
    end else begin
      logic [31:0] nrd;
      logic        nirq, tk, cw, adv;
      logic [2:0]  setv, clrv;
      nrd  = m_read(bus_addr);
      nirq = |(m_ev & m_en);
      tk   = (m_sel == 2'd3) && (m_pre >= 2 * int'(m_div) + 1);
      cw   = bus_we && bus_addr == 8'h00;
      adv  = tk && !cw;
      setv = '0;
      if (adv) begin
        if (m_cnt[3:0] == 4'hF) setv[1] = 1'b1;
        if (m_en[0] && (m_cnt + 32'd1) == m_al0) setv[0] = 1'b1;
        if (m_en[2] && (m_cnt + 32'd1) == m_al1) setv[2] = 1'b1;
      end
      if (cw) begin m_cnt = bus_wdata; m_pre = 0; end
      else if (tk) begin m_cnt = m_cnt + 32'd1; m_pre = 0; end
      else if (m_sel == 2'd3) m_pre++;
      clrv = '0;
      if (bus_we && bus_addr == 8'h08) begin
        clrv = {bus_wdata[4], bus_wdata[1], bus_wdata[0]};
        m_en = {bus_wdata[6], bus_wdata[3], bus_wdata[2]};
      end
      m_ev = (m_ev & ~clrv) | setv;
      if (bus_we) begin
        case (bus_addr)
          8'h04: m_al0  = bus_wdata;
          8'h18: m_al1  = bus_wdata;
          8'h0C: m_div  = bus_wdata[15:0];
          8'h14: m_deep = bus_wdata[7:0];
          8'h40: m_scr  = bus_wdata;
          8'h1C: m_sel  = (bus_wdata == 32'd3) ? 2'd3 : 2'd0;
          default: ;
        endcase
      end
      m_rd  = nrd;
      m_irq = nirq;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (live) begin
      n_chk++;
      if (bus_rdata !== m_rd) begin
        n_bad++;
        $display("FAIL R12 cycle %0d rdata actual %h expected %h", cyc, bus_rdata, m_rd);
      end
      n_chk++;
      if (irq_o !== m_irq) begin
        n_bad++;
        $display("FAIL R10 cycle %0d irq actual %0b expected %0b", cyc, irq_o, m_irq);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_lit(input logic [7:0] a, input logic [31:0] mask,
                        input logic [31:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    n_chk++;
    if ((bus_rdata & mask) !== exp) begin
      n_bad++;
      $display("FAIL %s addr %h actual %h expected %h", tag, a, bus_rdata & mask, exp);
    end
  endtask

  task automatic rd_mod(input logic [7:0] a, input string tag);
    bus_addr = a;
    @(negedge clk);
    n_chk++;
    if (bus_rdata !== m_rd) begin
      n_bad++;
      $display("FAIL %s addr %h actual %h expected %h", tag, a, bus_rdata, m_rd);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    live = 1;
    // R1 reset values
    n_chk++;
    if (irq_o !== 1'b0) begin n_bad++; $display("FAIL R1 irq actual %0b expected 0", irq_o); end
    rd_lit(8'h00, '1, 32'h0, "R1 counter");
    rd_lit(8'h04, '1, 32'h0, "R1 alarm0");
    rd_lit(8'h08, '1, 32'h0, "R1 status");
    rd_lit(8'h0C, '1, 32'd1023, "R1 divider");
    rd_lit(8'h1C, '1, 32'h0, "R1 selector");
    rd_lit(8'h40, '1, 32'h0, "R1 scratch");
    rd_lit(8'h18, '1, 32'h0, "R1 alarm1");

    // R11 storage registers
    wr(8'h0C, 32'd1);
    wr(8'h40, 32'hA5C3_0F96);
    wr(8'h14, 32'h0000_01B7);
    rd_lit(8'h40, '1, 32'hA5C3_0F96, "R11 scratch");
    rd_lit(8'h14, '1, 32'h0000_00B7, "R11 deep");
    rd_lit(8'h0C, '1, 32'd1, "R11 divider");

    // R2 halted time base and reserved selector codes
    idle(20);
    rd_lit(8'h00, '1, 32'h0, "R2 halted counter");
    wr(8'h1C, 32'd5);
    rd_lit(8'h1C, '1, 32'h0, "R2 reserved code");
    wr(8'h1C, 32'd3);
    rd_lit(8'h1C, '1, 32'd3, "R2 select");

    // R3 running, R12 unmapped read
    idle(30);
    rd_mod(8'h00, "R3 counting");
    rd_lit(8'h30, '1, 32'h0, "R12 unmapped");

    // R3 wrap
    wr(8'h00, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) rd_mod(8'h00, "R3 wrap");

    // R4 restart then watch each cycle
    idle(3);
    wr(8'h00, 32'h0000_0100);
    for (int i = 0; i < 10; i++) rd_mod(8'h00, "R4 restart");

    // R5 seconds event
    wr(8'h00, 32'h0000_000F);
    idle(6);
    rd_lit(8'h08, 32'h2, 32'h2, "R5 seconds event");

    // R6 alarm0
    wr(8'h08, 32'h0000_0004);
    wr(8'h04, 32'h0000_0025);
    wr(8'h00, 32'h0000_0022);
    idle(20);
    rd_lit(8'h08, 32'h1, 32'h1, "R6 alarm0 event");
    n_chk++;
    if (irq_o !== 1'b1) begin n_bad++; $display("FAIL R10 irq actual %0b expected 1", irq_o); end

    // R7 alarm1 disabled, then R9 rewrite while enabled
    wr(8'h18, 32'h0000_0040);
    wr(8'h00, 32'h0000_003E);
    idle(20);
    rd_lit(8'h08, 32'h10, 32'h0, "R7 alarm1 disabled");
    wr(8'h08, 32'h0000_0044);
    wr(8'h18, 32'h0000_0050);
    idle(90);
    rd_lit(8'h08, 32'h10, 32'h10, "R9 rewritten alarm1");

    // R8 write-one-to-clear with time base frozen
    wr(8'h1C, 32'd0);
    idle(2);
    wr(8'h08, 32'h0000_004C);
    rd_lit(8'h08, 32'h5F, 32'h5F, "R8 zeros keep events");
    wr(8'h08, 32'h0000_0013);
    rd_lit(8'h08, 32'h5F, 32'h00, "R8 ones clear");
    idle(2);
    n_chk++;
    if (irq_o !== 1'b0) begin n_bad++; $display("FAIL R10 irq actual %0b expected 0", irq_o); end
    rd_mod(8'h08, "R8 model");
    rd_lit(8'h40, '1, 32'hA5C3_0F96, "R11 scratch after run");

    // R4 write/tick collision sweep
    wr(8'h1C, 32'd3);
    for (int i = 0; i < 8; i++) begin
      idle(i);
      wr(8'h00, 32'h0000_0200 + i);
      rd_mod(8'h00, "R4 collision");
    end
    idle(12);
    finish_run();
  end

  initial begin
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog actual %0d cycles expected completion", cyc);
    finish_run();
  end
endmodule